// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Register

This block holds the latched interrupt events of a Fast Ethernet MAC. It sits at register offset 0x004 of the MAC register window. Single-cycle event pulses arrive from the transmit path, the receive path, MII management, the DMA engine and flow control. Each pulse sets a sticky bit. Software reads the register and clears bits by writing ones to them. A masked OR of the latched bits drives a registered interrupt line.

Some events are produced inside the block. A heartbeat checker looks for a collision within a programmable window after each transmission. Two byte-count detectors flag transmit and receive frames that exceed the programmed maximum length. A graceful-stop tracker merges three stop sources and reports when the transmitter has gone idle. A bus error latches its own event bit and turns the controller enable off in the same clock edge.

Top module: `eth_event_reg`

## Requirements
- R1: After reset every event bit is 0, `ctrl_en` is 0 and `irq` is 0.
- R2: A read with `bus_addr` equal to 0x004 returns the events in data bits 31 down to 19, in this order: heartbeat error (31), receive babble (30), transmit babble (29), graceful stop done (28), transmit frame (27), transmit buffer (26), receive frame (25), receive buffer (24), MII done (23), bus error (22), late collision (21), retry limit (20), transmit underrun (19). Bits 18..0 always read 0 and ignore writes. Any other address reads 0.
- R3: A write to 0x004 clears every event bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R4: An event pulse sets its bit at the next clock edge. If a write-one-clear hits the same bit in the same cycle, the set wins.
- R5: `ev_tx_frame`, `ev_tx_buf`, `ev_mii_done`, `ev_late_col`, `ev_retry_lim` and `ev_tx_underrun` each set their own bit.
- R6: An `ev_rx_desc` pulse sets the receive frame bit when `ev_rx_last` is 1. Otherwise it sets the receive buffer bit.
- R7: When `hb_chk_en` is 1, a `tx_done` pulse opens a window covering the next `hb_window` cycles (a value of 0 behaves as 1). If `col` stays low in every cycle of that window, the heartbeat error bit is set. A collision in any cycle of the window, or `hb_chk_en` at 0, leaves the bit clear.
- R8: A receive or transmit frame whose `rx_byte`/`tx_byte` count exceeds `max_frame_len` sets the receive or transmit babble bit at the byte that exceeds the limit. A frame of exactly `max_frame_len` bytes sets nothing. The count restarts at the frame-end pulse, and the frame is not cut short.
- R9: A pulse on `stop_sw_req`, `stop_pause_req` or `stop_rx_pause` arms a pending stop. The graceful stop done bit is set once `tx_active` is low, and never while `tx_active` is high.
- R10: `ctrl_en_set` turns `ctrl_en` on. `ev_bus_err` sets the bus error bit and clears `ctrl_en` at the same edge, and it wins over a simultaneous `ctrl_en_set`.
- R11: `irq` equals the OR of (event bits AND `irq_mask`) of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (ones clear) |
| bus_rdata | output | 32 | Read data |
| irq_mask | input | 32 | Interrupt enable mask |
| irq | output | 1 | Registered interrupt request |
| hb_chk_en | input | 1 | Heartbeat check enable |
| hb_window | input | 8 | Heartbeat window length in cycles |
| tx_done | input | 1 | End-of-transmission pulse |
| col | input | 1 | Collision indication |
| max_frame_len | input | 14 | Maximum frame length in bytes |
| tx_byte | input | 1 | Transmit byte strobe |
| tx_frame_end | input | 1 | Transmit frame end pulse |
| rx_byte | input | 1 | Receive byte strobe |
| rx_frame_end | input | 1 | Receive frame end pulse |
| tx_active | input | 1 | Transmitter busy with a frame |
| stop_sw_req | input | 1 | Software stop request pulse |
| stop_pause_req | input | 1 | Software pause-frame stop pulse |
| stop_rx_pause | input | 1 | Received pause frame stop pulse |
| ev_tx_frame | input | 1 | Transmit frame event |
| ev_tx_buf | input | 1 | Transmit buffer event |
| ev_rx_desc | input | 1 | Receive descriptor update |
| ev_rx_last | input | 1 | Descriptor update is the frame's last |
| ev_mii_done | input | 1 | MII transfer done |
| ev_bus_err | input | 1 | System bus error |
| ev_late_col | input | 1 | Late collision |
| ev_retry_lim | input | 1 | Retry limit reached |
| ev_tx_underrun | input | 1 | Transmit FIFO underrun |
| ctrl_en_set | input | 1 | Turns the controller enable on |
| ctrl_en | output | 1 | Controller enable |

## Verification
The checker evaluates the register update rule on every cycle. It checks that reserved bits stay zero, that a set always lands, that a written one clears every bit not set in the same cycle, and that the register holds when nothing touches it. It also checks that a bus error drops the enable and that the interrupt follows the masked OR. The timing of the internal detectors can only be shown by bench scenarios: where the heartbeat window ends, the exact babble byte count, and how the stop tracker waits for the transmitter to go idle. Those scenarios use directed frames and collisions placed at known cycles. Random pulses and writes are checked against a model of the register.

// File: rtl/eth_evt_pkg.sv
package eth_evt_pkg;
  localparam int EVT_W = 32;
  // Event order is MSB-first: event i lives in data bit 31-i.
  localparam int EB_HB   = EVT_W - 1 - 0;
  localparam int EB_BRX  = EVT_W - 1 - 1;
  localparam int EB_BTX  = EVT_W - 1 - 2;
  localparam int EB_GSC  = EVT_W - 1 - 3;
  localparam int EB_TXF  = EVT_W - 1 - 4;
  localparam int EB_TXB  = EVT_W - 1 - 5;
  localparam int EB_RXF  = EVT_W - 1 - 6;
  localparam int EB_RXB  = EVT_W - 1 - 7;
  localparam int EB_MII  = EVT_W - 1 - 8;
  localparam int EB_BERR = EVT_W - 1 - 9;
  localparam int EB_LC   = EVT_W - 1 - 10;
  localparam int EB_RL   = EVT_W - 1 - 11;
  localparam int EB_UN   = EVT_W - 1 - 12;
  localparam int N_EVT   = 13;
  localparam logic [EVT_W-1:0] EVT_LIVE = {{N_EVT{1'b1}}, {(EVT_W-N_EVT){1'b0}}};
endpackage

// File: rtl/eth_hb_check.sv
module eth_hb_check #(
  parameter int HB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hb_en,
  input  logic [HB_W-1:0] window,
  input  logic            tx_done,
  input  logic            col,
  output logic            hb_fail
);
  logic            armed_q, armed_d;
  logic [HB_W-1:0] cnt_q, cnt_d;
  logic            last_slot;

  assign last_slot = (cnt_q <= HB_W'(1));
  assign hb_fail   = armed_q && hb_en && !col && last_slot;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (tx_done && hb_en) begin
      armed_d = 1'b1;
      cnt_d   = window;
    end else if (armed_q) begin
      if (col || last_slot || !hb_en) armed_d = 1'b0;
      else                            cnt_d   = cnt_q - HB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/eth_babble_det.sv
module eth_babble_det #(
  parameter int FL_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FL_W-1:0] max_len,
  input  logic            byte_vld,
  input  logic            frame_end,
  output logic            babble
);
  logic [FL_W-1:0] cnt_q, cnt_d;
  logic            over_q, over_d;
  logic            cnt_en;

  assign babble = byte_vld && !over_q && (cnt_q == max_len);
  assign cnt_en = frame_end || (byte_vld && !over_q);

  always_comb begin
    cnt_d  = cnt_q;
    over_d = over_q;
    if (frame_end) begin
      cnt_d  = '0;
      over_d = 1'b0;
    end else if (babble) begin
      over_d = 1'b1;
    end else begin
      cnt_d = cnt_q + FL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      over_q <= over_d;
    end
  end
endmodule

// File: rtl/eth_gstop_track.sv
module eth_gstop_track (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sw,
  input  logic req_pause,
  input  logic req_rx_pause,
  input  logic tx_active,
  output logic stop_done
);
  logic pend_q, pend_d, any_req;

  assign any_req   = req_sw || req_pause || req_rx_pause;
  assign stop_done = (pend_q || any_req) && !tx_active;

  always_comb begin
    pend_d = (pend_q || any_req) && !stop_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/eth_event_reg.sv
module eth_event_reg
  import eth_evt_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              HB_W       = 8,
  parameter int              FL_W       = 14,
  parameter logic [ADDR_W-1:0] EVT_OFFSET = 12'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [EVT_W-1:0]  bus_wdata,
  output logic [EVT_W-1:0]  bus_rdata,
  input  logic [EVT_W-1:0]  irq_mask,
  output logic              irq,
  input  logic              hb_chk_en,
  input  logic [HB_W-1:0]   hb_window,
  input  logic              tx_done,
  input  logic              col,
  input  logic [FL_W-1:0]   max_frame_len,
  input  logic              tx_byte,
  input  logic              tx_frame_end,
  input  logic              rx_byte,
  input  logic              rx_frame_end,
  input  logic              tx_active,
  input  logic              stop_sw_req,
  input  logic              stop_pause_req,
  input  logic              stop_rx_pause,
  input  logic              ev_tx_frame,
  input  logic              ev_tx_buf,
  input  logic              ev_rx_desc,
  input  logic              ev_rx_last,
  input  logic              ev_mii_done,
  input  logic              ev_bus_err,
  input  logic              ev_late_col,
  input  logic              ev_retry_lim,
  input  logic              ev_tx_underrun,
  input  logic              ctrl_en_set,
  output logic              ctrl_en
);
  logic             hb_fail, babble_rx, babble_tx, stop_done;
  logic             wr_hit, evt_en;
  logic [EVT_W-1:0] set_vec, clr_vec, evt_d, evt_q;
  logic             en_d, en_q, irq_d, irq_q;

  eth_hb_check #(.HB_W(HB_W)) u_hb (
    .clk(clk), .rst_n(rst_n), .hb_en(hb_chk_en), .window(hb_window),
    .tx_done(tx_done), .col(col), .hb_fail(hb_fail)
  );

  eth_babble_det #(.FL_W(FL_W)) u_babble_rx (
    .clk(clk), .rst_n(rst_n), .max_len(max_frame_len),
    .byte_vld(rx_byte), .frame_end(rx_frame_end), .babble(babble_rx)
  );

  eth_babble_det #(.FL_W(FL_W)) u_babble_tx (
    .clk(clk), .rst_n(rst_n), .max_len(max_frame_len),
    .byte_vld(tx_byte), .frame_end(tx_frame_end), .babble(babble_tx)
  );

  eth_gstop_track u_gstop (
    .clk(clk), .rst_n(rst_n), .req_sw(stop_sw_req), .req_pause(stop_pause_req),
    .req_rx_pause(stop_rx_pause), .tx_active(tx_active), .stop_done(stop_done)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[EB_HB]   = hb_fail;
    set_vec[EB_BRX]  = babble_rx;
    set_vec[EB_BTX]  = babble_tx;
    set_vec[EB_GSC]  = stop_done;
    set_vec[EB_TXF]  = ev_tx_frame;
    set_vec[EB_TXB]  = ev_tx_buf;
    set_vec[EB_RXF]  = ev_rx_desc && ev_rx_last;
    set_vec[EB_RXB]  = ev_rx_desc && !ev_rx_last;
    set_vec[EB_MII]  = ev_mii_done;
    set_vec[EB_BERR] = ev_bus_err;
    set_vec[EB_LC]   = ev_late_col;
    set_vec[EB_RL]   = ev_retry_lim;
    set_vec[EB_UN]   = ev_tx_underrun;
  end

  assign wr_hit  = bus_wr && (bus_addr == EVT_OFFSET);
  assign clr_vec = wr_hit ? bus_wdata : '0;
  assign evt_en  = wr_hit || (|set_vec);
  // Set is applied after clear so a coincident hardware event survives.
  assign evt_d   = ((evt_q & ~clr_vec) | set_vec) & EVT_LIVE;

  always_comb begin
    en_d = en_q;
    if (ev_bus_err)       en_d = 1'b0;
    else if (ctrl_en_set) en_d = 1'b1;
  end

  assign irq_d = |(evt_q & irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else if (evt_en) evt_q <= evt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  assign bus_rdata = (bus_addr == EVT_OFFSET) ? evt_q : '0;
  assign ctrl_en   = en_q;
  assign irq       = irq_q;
endmodule

// File: rtl/eth_event_reg_chk.sv
module eth_event_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_q,
  input logic [31:0] set_vec,
  input logic        wr_hit,
  input logic [31:0] bus_wdata,
  input logic [31:0] irq_mask,
  input logic        irq,
  input logic        ev_bus_err,
  input logic        ctrl_en
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[18:0] == 19'd0);

  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((evt_q & $past(bus_wdata) & ~$past(set_vec)) == 32'd0));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && set_vec == 32'd0) |=> $stable(evt_q));

  a_r10_buserr_disables: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> (!ctrl_en && evt_q[22]));

  a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(evt_q) & $past(irq_mask))));
endmodule

bind eth_event_reg eth_event_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_q(evt_q), .set_vec(set_vec), .wr_hit(wr_hit),
  .bus_wdata(bus_wdata), .irq_mask(irq_mask), .irq(irq),
  .ev_bus_err(ev_bus_err), .ctrl_en(ctrl_en)
);

// File: tb/tb_eth_event_reg.sv
`timescale 1ns/1ps
module tb_eth_event_reg;
  localparam logic [11:0] EVA = 12'h004;
  localparam logic [31:0] LIVE = 32'hFFF8_0000;
  localparam int B_HB = 31, B_BRX = 30, B_BTX = 29, B_GSC = 28, B_TXF = 27, B_TXB = 26;
  localparam int B_RXF = 25, B_RXB = 24, B_MII = 23, B_BERR = 22, B_LC = 21, B_RL = 20, B_UN = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr;
  logic bus_wr;
  logic [31:0] bus_wdata, bus_rdata, irq_mask;
  logic irq, hb_chk_en, tx_done, col, tx_byte, tx_frame_end, rx_byte, rx_frame_end;
  logic [7:0] hb_window;
  logic [13:0] max_frame_len;
  logic tx_active, stop_sw_req, stop_pause_req, stop_rx_pause;
  logic ev_tx_frame, ev_tx_buf, ev_rx_desc, ev_rx_last, ev_mii_done, ev_bus_err;
  logic ev_late_col, ev_retry_lim, ev_tx_underrun, ctrl_en_set, ctrl_en;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  eth_event_reg dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    bus_addr = EVA; bus_wr = 0; bus_wdata = '0; irq_mask = '0;
    hb_chk_en = 0; hb_window = 8'd4; tx_done = 0; col = 0; max_frame_len = 14'd5;
    tx_byte = 0; tx_frame_end = 0; rx_byte = 0; rx_frame_end = 0; tx_active = 0;
    stop_sw_req = 0; stop_pause_req = 0; stop_rx_pause = 0;
    ev_tx_frame = 0; ev_tx_buf = 0; ev_rx_desc = 0; ev_rx_last = 0; ev_mii_done = 0;
    ev_bus_err = 0; ev_late_col = 0; ev_retry_lim = 0; ev_tx_underrun = 0; ctrl_en_set = 0;
  endtask

  task automatic clear_all();
    bus_addr = EVA; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF; tick();
    bus_wr = 0; bus_wdata = '0;
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [31:0] sets,
                                             input logic wr, input logic [31:0] wd);
    return ((cur & ~(wr ? wd : 32'd0)) | sets) & LIVE;
  endfunction

  task automatic send_frame(input bit rx, input int n);
    for (int i = 0; i < n; i++) begin
      if (rx) rx_byte = 1; else tx_byte = 1;
      tick();
    end
    rx_byte = 0; tx_byte = 0;
    if (rx) rx_frame_end = 1; else tx_frame_end = 1;
    tick();
    rx_frame_end = 0; tx_frame_end = 0;
  endtask

  task automatic hb_run(input int col_slot, input bit en);
    hb_chk_en = en; tx_done = 1; tick(); tx_done = 0;
    for (int s = 1; s <= 8; s++) begin
      col = (s == col_slot);
      tick();
    end
    col = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] mdl, prev, sets;
    logic men;
    void'($urandom(32'd4242));
    idle_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 events", bus_rdata, 32'd0);
    chk("R1 ctrl_en", {31'd0, ctrl_en}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R5 direct events, R2 other address reads zero
    ev_tx_frame = 1; ev_mii_done = 1; ev_tx_underrun = 1; tick();
    ev_tx_frame = 0; ev_mii_done = 0; ev_tx_underrun = 0;
    chk("R5 direct bits", bus_rdata, (32'd1 << B_TXF) | (32'd1 << B_MII) | (32'd1 << B_UN));
    bus_addr = 12'h008; #1;
    chk("R2 other address", bus_rdata, 32'd0);
    bus_addr = EVA; #1;
    // R3 partial clear, R2 reserved ignores writes
    bus_wr = 1; bus_wdata = (32'd1 << B_MII) | 32'h0007_FFFF; tick(); bus_wr = 0;
    chk("R3 partial w1c", bus_rdata, (32'd1 << B_TXF) | (32'd1 << B_UN));
    // R4 set wins over clear
    ev_tx_frame = 1; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF; tick();
    ev_tx_frame = 0; bus_wr = 0;
    chk("R4 set wins", bus_rdata, 32'd1 << B_TXF);
    clear_all();

    // R6 receive descriptors
    ev_rx_desc = 1; ev_rx_last = 0; tick();
    chk("R6 non-last", bus_rdata, 32'd1 << B_RXB);
    ev_rx_last = 1; clear_all();
    chk("R6 last", bus_rdata & ~(32'd1 << B_RXF), 32'd0);
    ev_rx_desc = 0; ev_rx_last = 0; clear_all();

    // R7 heartbeat
    hb_run(3, 1'b1);
    chk("R7 col in window", bus_rdata, 32'd0);
    hb_run(4, 1'b1);
    chk("R7 col in last slot", bus_rdata, 32'd0);
    hb_run(5, 1'b1);
    chk("R7 col after window", bus_rdata, 32'd1 << B_HB);
    clear_all();
    hb_run(0, 1'b0);
    chk("R7 disabled", bus_rdata, 32'd0);
    hb_chk_en = 0;

    // R8 babble
    send_frame(1'b1, 5);
    chk("R8 rx exact max", bus_rdata, 32'd0);
    send_frame(1'b1, 6);
    chk("R8 rx over max", bus_rdata, 32'd1 << B_BRX);
    clear_all();
    send_frame(1'b0, 9);
    chk("R8 tx over max", bus_rdata, 32'd1 << B_BTX);
    clear_all();
    send_frame(1'b0, 4);
    chk("R8 tx under max after restart", bus_rdata, 32'd0);

    // R9 graceful stop, three sources
    tx_active = 1; stop_sw_req = 1; tick(); stop_sw_req = 0; tick(); tick();
    chk("R9 held while busy", bus_rdata, 32'd0);
    tx_active = 0; tick();
    chk("R9 sw stop done", bus_rdata, 32'd1 << B_GSC);
    clear_all();
    tx_active = 1; stop_pause_req = 1; tick(); stop_pause_req = 0; tx_active = 0; tick();
    chk("R9 pause request", bus_rdata, 32'd1 << B_GSC);
    clear_all();
    stop_rx_pause = 1; tick(); stop_rx_pause = 0;
    chk("R9 rx pause idle", bus_rdata, 32'd1 << B_GSC);
    clear_all();

    // R10 bus error
    ctrl_en_set = 1; tick(); ctrl_en_set = 0;
    chk("R10 enable on", {31'd0, ctrl_en}, 32'd1);
    ev_bus_err = 1; ctrl_en_set = 1; tick(); ev_bus_err = 0; ctrl_en_set = 0;
    chk("R10 enable off", {31'd0, ctrl_en}, 32'd0);
    chk("R10 bus error bit", bus_rdata, 32'd1 << B_BERR);
    // R11 irq masked
    irq_mask = 32'd1 << B_TXF; tick();
    chk("R11 masked out", {31'd0, irq}, 32'd0);
    irq_mask = 32'd1 << B_BERR; tick();
    chk("R11 masked in", {31'd0, irq}, 32'd1);
    clear_all();

    // Random phase: R2 R3 R4 R5 R6 R10 R11 against the model
    mdl = '0; men = ctrl_en;
    for (int c = 0; c < 400; c++) begin
      ev_tx_frame = ($urandom % 8) == 0; ev_tx_buf = ($urandom % 8) == 0;
      ev_rx_desc = ($urandom % 6) == 0; ev_rx_last = $urandom % 2;
      ev_mii_done = ($urandom % 8) == 0; ev_late_col = ($urandom % 10) == 0;
      ev_retry_lim = ($urandom % 10) == 0; ev_tx_underrun = ($urandom % 10) == 0;
      ev_bus_err = ($urandom % 20) == 0; ctrl_en_set = ($urandom % 5) == 0;
      bus_wr = ($urandom % 3) == 0; bus_wdata = $urandom;
      bus_addr = (($urandom % 4) == 0) ? 12'h00C : EVA;
      irq_mask = $urandom;
      sets = '0;
      sets[B_TXF] = ev_tx_frame; sets[B_TXB] = ev_tx_buf;
      sets[B_RXF] = ev_rx_desc & ev_rx_last; sets[B_RXB] = ev_rx_desc & ~ev_rx_last;
      sets[B_MII] = ev_mii_done; sets[B_LC] = ev_late_col; sets[B_RL] = ev_retry_lim;
      sets[B_UN] = ev_tx_underrun; sets[B_BERR] = ev_bus_err;
      prev = mdl;
      mdl = model_next(mdl, sets, bus_wr && bus_addr == EVA, bus_wdata);
      men = ev_bus_err ? 1'b0 : (ctrl_en_set ? 1'b1 : men);
      tick();
      chk("R11 random irq", {31'd0, irq}, {31'd0, |(prev & irq_mask)});
      chk("R10 random enable", {31'd0, ctrl_en}, {31'd0, men});
      chk("R3 random register", bus_rdata, (bus_addr == EVA) ? mdl : 32'd0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule